// File: doc/BRIEF.md
# Serial Program Loader

After reset this block takes a program arriving on an asynchronous serial line and writes it, one 32-bit word at a time, into an instruction memory. Bytes are received with sixteen-fold oversampling. Each group of four bytes becomes one word: the first byte received fills bits 7:0 and the fourth fills bits 31:24. Words go to consecutive word addresses, starting at zero.

While loading, the block holds the processor's pipeline stopped by keeping its run enable low. A fixed end word, 0xBAADF00D, closes the program. That word is not stored. On seeing it, the loader clears its byte and word state, raises the run enable and then ignores the line. The core then starts fetching at address zero. Only an asynchronous active-low reset starts a new load.

Top module: `boot_loader`

## Requirements
- R1: While reset is asserted and right after it, `run_en` is 0 and `imem_we` is 0.
- R2: Four good bytes form one word in little-endian order: byte k of the group lands in bits 8k+7:8k.
- R3: Stored words go to word addresses 0, 1, 2 and so on, in the order they arrive.
- R4: When a group of four bytes equals 0xBAADF00D, nothing is written, and `run_en` goes to 1 before the stop bit of that last byte has ended.
- R5: Once `run_en` is 1 it stays 1, and any later line activity causes no write.
- R6: A byte whose stop bit samples low is dropped and does not take a position in the current word.
- R7: A falling edge that is high again at the middle of the start bit (the eighth of sixteen samples) is not taken as a byte.
- R8: Asserting reset drops `run_en`, discards a partly received word and restarts the write address at 0.
- R9: `imem_we` is a single-cycle pulse for each stored word.
- R10: The sample tick comes from a fractional accumulator at sixteen times the baud rate of the system clock (defaults 25 MHz and 115200 baud).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_rx | input | 1 | Serial receive line, idle high |
| imem_we | output | 1 | Instruction memory write strobe |
| imem_addr | output | ADDR_W | Word address of the write |
| imem_wdata | output | 32 | Word being written |
| run_en | output | 1 | High once loading is over; releases the pipeline |

## Verification
The hardest cases to reach from the ports are the ones where the byte framing goes wrong in the middle of a word. One is a stop bit that samples low after one good byte. The other is a short low pulse on an idle line. The stimulus holds a stop bit low only long enough to cover its mid-bit sample, and it pulses the line low for less than half a bit. It then sends further bytes and checks that the stored word still has exactly the intended byte layout. A partial word is also cut short by a reset, to show that the byte position and the address both start over.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  localparam int unsigned BYTES_PER_WORD = 4;
endpackage

// File: rtl/ldr_baud_gen.sv
module ldr_baud_gen #(
  parameter int unsigned CLK_HZ = 25_000_000,
  parameter int unsigned BAUD   = 115_200,
  parameter int unsigned OVS    = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned INC   = OVS * BAUD;
  localparam int unsigned ACC_W = $clog2(CLK_HZ + INC) + 1;

  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic             tick_d;

  always_comb begin
    sum = acc_q + ACC_W'(INC);
    if (sum >= ACC_W'(CLK_HZ)) begin
      acc_d  = sum - ACC_W'(CLK_HZ);
      tick_d = 1'b1;
    end else begin
      acc_d  = sum;
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      tick  <= tick_d;
    end
  end
endmodule

// File: rtl/ldr_uart_rx.sv
module ldr_uart_rx
  import ldr_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  output logic       byte_vld,
  output logic [7:0] byte_data
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  logic             sync1, rx_s;
  rx_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic             vld_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      rx_s  <= 1'b1;
    end else begin
      sync1 <= rx;
      rx_s  <= sync1;
    end
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    unique case (st_q)
      RX_IDLE: if (!rx_s) begin
        st_d  = RX_START;
        cnt_d = '0;
      end
      RX_START: if (tick) begin
        if (cnt_q == MID) begin
          cnt_d = '0;
          bit_d = '0;
          st_d  = rx_s ? RX_IDLE : RX_DATA;
        end else cnt_d = cnt_q + 1'b1;
      end
      RX_DATA: if (tick) begin
        if (cnt_q == LAST) begin
          cnt_d = '0;
          sh_d  = {rx_s, sh_q[7:1]};
          if (bit_q == 3'd7) st_d = RX_STOP;
          else               bit_d = bit_q + 1'b1;
        end else cnt_d = cnt_q + 1'b1;
      end
      RX_STOP: if (tick) begin
        if (cnt_q == LAST) begin
          vld_d = rx_s;
          st_d  = RX_IDLE;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= RX_IDLE;
      cnt_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      byte_vld <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      byte_vld <= vld_d;
    end
  end

  assign byte_data = sh_q;
endmodule

// File: rtl/ldr_word_pack.sv
module ldr_word_pack
  import ldr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter logic [31:0] MARKER = 32'hBAAD_F00D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  output logic              imem_we,
  output logic [ADDR_W-1:0] imem_addr,
  output logic [31:0]       imem_wdata,
  output logic              run_en
);
  localparam int unsigned IDX_W = $clog2(BYTES_PER_WORD);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [23:0]       part_q, part_d;
  logic [ADDR_W-1:0] nxt_q, nxt_d, addr_d;
  logic [31:0]       full, data_d;
  logic              we_d, run_d;

  always_comb begin
    idx_d  = idx_q;
    part_d = part_q;
    nxt_d  = nxt_q;
    addr_d = imem_addr;
    data_d = imem_wdata;
    run_d  = run_en;
    we_d   = 1'b0;
    full   = {byte_data, part_q};
    if (!run_en && byte_vld) begin
      if (idx_q == IDX_W'(BYTES_PER_WORD - 1)) begin
        idx_d  = '0;
        part_d = '0;
        if (full == MARKER) begin
          run_d = 1'b1;
          nxt_d = '0;
        end else begin
          we_d   = 1'b1;
          addr_d = nxt_q;
          data_d = full;
          nxt_d  = nxt_q + 1'b1;
        end
      end else begin
        part_d[idx_q*8 +: 8] = byte_data;
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      part_q     <= '0;
      nxt_q      <= '0;
      imem_we    <= 1'b0;
      imem_addr  <= '0;
      imem_wdata <= '0;
      run_en     <= 1'b0;
    end else begin
      idx_q      <= idx_d;
      part_q     <= part_d;
      nxt_q      <= nxt_d;
      imem_we    <= we_d;
      imem_addr  <= addr_d;
      imem_wdata <= data_d;
      run_en     <= run_d;
    end
  end
endmodule

// File: rtl/boot_loader.sv
module boot_loader #(
  parameter int unsigned CLK_HZ = 25_000_000,
  parameter int unsigned BAUD   = 115_200,
  parameter int unsigned OVS    = 16,
  parameter int unsigned ADDR_W = 10,
  parameter logic [31:0] MARKER = 32'hBAAD_F00D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uart_rx,
  output logic              imem_we,
  output logic [ADDR_W-1:0] imem_addr,
  output logic [31:0]       imem_wdata,
  output logic              run_en
);
  logic       rst_m, rst_sn;
  logic       tick, byte_vld;
  logic [7:0] byte_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m  <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_m  <= 1'b1;
      rst_sn <= rst_m;
    end
  end

  ldr_baud_gen #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(OVS)) i_baud (
    .clk(clk), .rst_n(rst_sn), .tick(tick)
  );

  ldr_uart_rx #(.OVS(OVS)) i_rx (
    .clk(clk), .rst_n(rst_sn), .tick(tick), .rx(uart_rx),
    .byte_vld(byte_vld), .byte_data(byte_data)
  );

  ldr_word_pack #(.ADDR_W(ADDR_W), .MARKER(MARKER)) i_pack (
    .clk(clk), .rst_n(rst_sn), .byte_vld(byte_vld), .byte_data(byte_data),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
    .run_en(run_en)
  );
endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter logic [31:0] MARKER = 32'hBAAD_F00D
) (
  input logic              clk,
  input logic              rst_n,
  input logic              imem_we,
  input logic [ADDR_W-1:0] imem_addr,
  input logic [31:0]       imem_wdata,
  input logic              run_en
);
  logic [ADDR_W-1:0] exp_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       exp_addr <= '0;
    else if (imem_we) exp_addr <= exp_addr + 1'b1;
  end

  // R3
  seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_we |-> imem_addr == exp_addr);

  // R4
  no_marker_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_we |-> imem_wdata != MARKER);

  // R5
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> run_en);

  // R5
  no_write_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> !imem_we);

  // R9
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_we |=> !imem_we);
endmodule

bind boot_loader boot_loader_chk #(.ADDR_W(ADDR_W), .MARKER(MARKER)) i_chk (
  .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_addr(imem_addr),
  .imem_wdata(imem_wdata), .run_en(run_en)
);

// File: tb/test_boot_loader.sv
module test_boot_loader;
  localparam int unsigned AW  = 10;
  localparam int unsigned BIT = 32; // clocks per bit: 3.2 MHz / 100 kbaud

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          uart_rx = 1'b1;
  logic          imem_we;
  logic [AW-1:0] imem_addr;
  logic [31:0]   imem_wdata;
  logic          run_en;

  int checks = 0;
  int errors = 0;
  int writes = 0;
  int cyc = 0;
  logic [AW-1:0] addr_exp = '0;
  logic [AW+31:0] sb_q[$];
  logic prev_we = 1'b0;

  always #2 clk = ~clk;

  boot_loader #(.CLK_HZ(3_200_000), .BAUD(100_000), .OVS(16), .ADDR_W(AW)) i_boot_loader (
    .clk(clk), .rst_n(rst_n), .uart_rx(uart_rx), .imem_we(imem_we),
    .imem_addr(imem_addr), .imem_wdata(imem_wdata), .run_en(run_en)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  // monitor: compare each write against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (imem_we) begin
        writes++;
        chk(!prev_we, "R9", 64'(prev_we), 64'd0);
        if (sb_q.size() == 0) begin
          chk(1'b0, "R5", 64'(imem_wdata), 64'd0);
        end else begin
          logic [AW+31:0] e;
          e = sb_q.pop_front();
          chk(imem_addr == e[AW+31:32], "R3", 64'(imem_addr), 64'(e[AW+31:32]));
          chk(imem_wdata == e[31:0], "R2", 64'(imem_wdata), 64'(e[31:0]));
        end
      end
      prev_we = imem_we;
    end else prev_we = 1'b0;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit good_stop);
    uart_rx = 1'b0;
    wait_clk(BIT);
    for (int i = 0; i < 8; i++) begin
      uart_rx = b[i];
      wait_clk(BIT);
    end
    if (good_stop) begin
      uart_rx = 1'b1;
      wait_clk(BIT);
    end else begin
      uart_rx = 1'b0;
      wait_clk(24);
      uart_rx = 1'b1;
      wait_clk(2 * BIT);
    end
  endtask

  task automatic push_exp(input logic [31:0] w);
    sb_q.push_back({addr_exp, w});
    addr_exp++;
  endtask

  task automatic send_word(input logic [31:0] w, input bit expect_write);
    if (expect_write) push_exp(w);
    for (int i = 0; i < 4; i++) send_byte(w[i*8 +: 8], 1'b1);
    wait_clk(4);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_clk(6);
    chk(run_en == 1'b0, "R1", 64'(run_en), 64'd0);
    chk(imem_we == 1'b0, "R1", 64'(imem_we), 64'd0);
    rst_n = 1'b1;
    wait_clk(8);
    chk(run_en == 1'b0, "R1", 64'(run_en), 64'd0);
    addr_exp = '0;
  endtask

  initial begin
    do_reset();
    // R2 R3 R10: plain words at the divided baud rate
    send_word(32'h1234_5678, 1'b1);
    send_word(32'hA5C3_0F01, 1'b1);
    send_word(32'h0000_0000, 1'b1);
    send_word(32'hFFFF_FFFF, 1'b1);
    chk(writes == 4, "R3", 64'(writes), 64'd4);

    // R6: bad stop bit inside a word is dropped
    push_exp(32'h4433_2211);
    send_byte(8'h11, 1'b1);
    send_byte(8'h99, 1'b0);
    send_byte(8'h22, 1'b1);
    send_byte(8'h33, 1'b1);
    send_byte(8'h44, 1'b1);
    wait_clk(4);
    chk(writes == 5, "R6", 64'(writes), 64'd5);

    // R7: short low pulse is not a start bit
    uart_rx = 1'b0;
    wait_clk(6);
    uart_rx = 1'b1;
    wait_clk(3 * BIT);
    send_word(32'h0BAD_BEEF, 1'b1);
    chk(writes == 6, "R7", 64'(writes), 64'd6);

    // R4: end word is not stored and releases the pipeline
    send_byte(8'h0D, 1'b1);
    send_byte(8'hF0, 1'b1);
    send_byte(8'hAD, 1'b1);
    chk(run_en == 1'b0, "R4", 64'(run_en), 64'd0);
    send_byte(8'hBA, 1'b1);
    chk(run_en == 1'b1, "R4", 64'(run_en), 64'd1);
    chk(writes == 6, "R4", 64'(writes), 64'd6);

    // R5: line activity after hand-off is ignored
    send_word(32'hDEAD_BEEF, 1'b0);
    send_word(32'h1111_2222, 1'b0);
    chk(writes == 6, "R5", 64'(writes), 64'd6);
    chk(run_en == 1'b1, "R5", 64'(run_en), 64'd1);

    // R8: reset restarts loading, address and byte position
    do_reset();
    send_byte(8'hEE, 1'b1);
    send_byte(8'hEE, 1'b1);
    do_reset();
    chk(run_en == 1'b0, "R8", 64'(run_en), 64'd0);
    send_word(32'h55AA_7733, 1'b1);
    chk(writes == 7, "R8", 64'(writes), 64'd7);
    send_word(32'h0102_0304, 1'b1);
    chk(sb_q.size() == 0, "R8", 64'(sb_q.size()), 64'd0);
    chk(writes == 8, "R3", 64'(writes), 64'd8);
    finish_run();
  end
endmodule